// File: doc/BRIEF.md
# Dual-Port RAM with Mailbox Interrupts

A synchronous 1K x 8 memory reached through two independent ports, called left and right. Each port has its own enable, write select, output enable, 10-bit address, 8-bit write data and registered 8-bit read data. The two ports share one clock, and either port can read or write any word.

The two highest addresses double as mailboxes between the ports. When the right port writes word 0x3FE, the left port's interrupt goes active. When the left port writes word 0x3FF, the right port's interrupt goes active. Each receiver clears its own interrupt by accessing its own mailbox with the enable and output enable both active. The stored message bytes are ordinary RAM contents, so software can ignore the interrupts and use the two words as plain storage.

A parameter removes the mailbox logic. In that variant both interrupt outputs stay inactive.

Top module: `mbox_dpram`

## Requirements
- R1: While reset is held and right after it, both read data outputs are 0x00 and both interrupt outputs (active low) are 1.
- R2: A word written by either port can be read back by either port. A read happens when enable=1, write=0 and output enable=1, and its data appears on that port's read data output one clock after the address is presented.
- R3: A port with enable=0 writes nothing, leaves its read data output unchanged, and leaves both interrupt flags unchanged.
- R4: A right-port write (enable=1, write=1) to address 0x3FE drives the left interrupt low from the next clock on.
- R5: The left interrupt returns high one clock after the left port presents address 0x3FE with enable=1 and output enable=1. The write select is a don't-care for this clearing.
- R6: A left-port write to address 0x3FF drives the right interrupt low. The right port clears it by presenting 0x3FF with enable=1 and output enable=1.
- R7: The mailbox words store and return data like any other word. A port writing its own mailbox address (left to 0x3FE, right to 0x3FF) raises no interrupt.
- R8: When a flag is set and cleared in the same cycle, it ends up set.
- R9: When both ports write the same address in the same cycle, the left port's data is stored.
- R10: A read of an address that the other port writes in the same cycle returns the word's previous contents.
- R11: A port with enable=1, write=0 and output enable=0 leaves its read data output unchanged, and at its mailbox address it does not clear its flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Synchronous reset, active low |
| l_en | input | 1 | Left port enable |
| l_wr | input | 1 | Left port write select (1 = write) |
| l_oe | input | 1 | Left port output enable |
| l_addr | input | 10 | Left port address |
| l_wdata | input | 8 | Left port write data |
| l_rdata | output | 8 | Left port registered read data |
| l_irq_n | output | 1 | Left port interrupt, active low |
| r_en | input | 1 | Right port enable |
| r_wr | input | 1 | Right port write select (1 = write) |
| r_oe | input | 1 | Right port output enable |
| r_addr | input | 10 | Right port address |
| r_wdata | input | 8 | Right port write data |
| r_rdata | output | 8 | Right port registered read data |
| r_irq_n | output | 1 | Right port interrupt, active low |

## Verification
The mailbox function is tried with several patterns, and each one tells a different pair of behaviours apart:
- A write to the opposite mailbox is set against a write to the port's own mailbox, which separates flag raising from plain storage.
- A clear done with the write select low is set against one done with it high, which shows that write is a don't-care.
- An access with the output enable low shows that a clear needs the output enable.
- A receiver read that lands in the same cycle as a new sender write exposes both the set-over-clear priority and the read-before-write ordering.
- A same-address write collision and disabled-port stimulus show the port priority and that an idle port has no side effects.

// File: rtl/mbox_dpram_pkg.sv
package mbox_dpram_pkg;

   typedef enum logic {
      SIDE_LEFT  = 1'b0,
      SIDE_RIGHT = 1'b1
   } side_e;

   typedef struct packed {
      logic wr_stb;   // enabled write
      logic rd_stb;   // enabled read that updates read data
      logic look_stb; // enabled with output enable, write ignored
   } port_ctl_t;

endpackage

// File: rtl/mbox_dpram_port_dec.sv
module mbox_dpram_port_dec
   import mbox_dpram_pkg::*;
#(
   parameter int    ADDR_W = 10,
   parameter side_e SIDE   = SIDE_LEFT
) (
   input  logic              en,
   input  logic              wr,
   input  logic              oe,
   input  logic [ADDR_W-1:0] addr,
   output port_ctl_t         ctl,
   output logic              own_hit,
   output logic              far_hit
);
   localparam int DEPTH = 1 << ADDR_W;
   localparam logic [ADDR_W-1:0] BOX_LEFT  = ADDR_W'(DEPTH - 2);
   localparam logic [ADDR_W-1:0] BOX_RIGHT = ADDR_W'(DEPTH - 1);
   localparam logic [ADDR_W-1:0] BOX_OWN   = (SIDE == SIDE_LEFT) ? BOX_LEFT  : BOX_RIGHT;
   localparam logic [ADDR_W-1:0] BOX_FAR   = (SIDE == SIDE_LEFT) ? BOX_RIGHT : BOX_LEFT;

   always_comb begin
      ctl.wr_stb   = en & wr;
      ctl.rd_stb   = en & ~wr & oe;
      ctl.look_stb = en & oe;
      own_hit      = (addr == BOX_OWN);
      far_hit      = (addr == BOX_FAR);
   end
endmodule

// File: rtl/mbox_dpram_array.sv
module mbox_dpram_array #(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              a_we,
   input  logic              a_re,
   input  logic [ADDR_W-1:0] a_addr,
   input  logic [DATA_W-1:0] a_wdata,
   output logic [DATA_W-1:0] a_rdata,
   input  logic              b_we,
   input  logic              b_re,
   input  logic [ADDR_W-1:0] b_addr,
   input  logic [DATA_W-1:0] b_wdata,
   output logic [DATA_W-1:0] b_rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] store [DEPTH];
   logic              b_blocked;

   // port a (left) owns a same-address collision
   assign b_blocked = a_we & (a_addr == b_addr);

   always_ff @(posedge clk) begin
      if (a_we)
         store[a_addr] <= a_wdata;
      if (b_we && !b_blocked)
         store[b_addr] <= b_wdata;
   end

   // reads take the contents before this edge's writes
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         a_rdata <= '0;
         b_rdata <= '0;
      end else begin
         if (a_re)
            a_rdata <= store[a_addr];
         if (b_re)
            b_rdata <= store[b_addr];
      end
   end
endmodule

// File: rtl/mbox_dpram_flag.sv
module mbox_dpram_flag #(
   parameter bit MBOX_EN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic irq_n
);
   generate
      if (MBOX_EN) begin : g_live
         logic pending;
         always_ff @(posedge clk) begin
            if (!rst_n)
               pending <= 1'b0;
            else if (set_i)
               pending <= 1'b1;
            else if (clr_i)
               pending <= 1'b0;
         end
         assign irq_n = ~pending;
      end else begin : g_off
         logic unused_in;
         assign unused_in = clk ^ rst_n ^ set_i ^ clr_i;
         assign irq_n     = 1'b1;
      end
   endgenerate
endmodule

// File: rtl/mbox_dpram.sv
module mbox_dpram
   import mbox_dpram_pkg::*;
#(
   parameter int ADDR_W  = 10,
   parameter int DATA_W  = 8,
   parameter bit MBOX_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              l_en,
   input  logic              l_wr,
   input  logic              l_oe,
   input  logic [ADDR_W-1:0] l_addr,
   input  logic [DATA_W-1:0] l_wdata,
   output logic [DATA_W-1:0] l_rdata,
   output logic              l_irq_n,
   input  logic              r_en,
   input  logic              r_wr,
   input  logic              r_oe,
   input  logic [ADDR_W-1:0] r_addr,
   input  logic [DATA_W-1:0] r_wdata,
   output logic [DATA_W-1:0] r_rdata,
   output logic              r_irq_n
);
   localparam int NSIDE = 2;

   generate
      if (ADDR_W < 2 || ADDR_W > 16) begin : g_bad_addr
         $error("mbox_dpram: ADDR_W must lie in 2..16");
      end
      if (DATA_W < 1 || DATA_W > 64) begin : g_bad_data
         $error("mbox_dpram: DATA_W must lie in 1..64");
      end
   endgenerate

   port_ctl_t ctl     [NSIDE];
   logic      own_hit [NSIDE];
   logic      far_hit [NSIDE];
   logic      irq_n   [NSIDE];

   mbox_dpram_port_dec #(.ADDR_W(ADDR_W), .SIDE(SIDE_LEFT)) u_dec_l (
      .en(l_en), .wr(l_wr), .oe(l_oe), .addr(l_addr),
      .ctl(ctl[0]), .own_hit(own_hit[0]), .far_hit(far_hit[0])
   );

   mbox_dpram_port_dec #(.ADDR_W(ADDR_W), .SIDE(SIDE_RIGHT)) u_dec_r (
      .en(r_en), .wr(r_wr), .oe(r_oe), .addr(r_addr),
      .ctl(ctl[1]), .own_hit(own_hit[1]), .far_hit(far_hit[1])
   );

   mbox_dpram_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
      .clk(clk), .rst_n(rst_n),
      .a_we(ctl[0].wr_stb), .a_re(ctl[0].rd_stb), .a_addr(l_addr),
      .a_wdata(l_wdata), .a_rdata(l_rdata),
      .b_we(ctl[1].wr_stb), .b_re(ctl[1].rd_stb), .b_addr(r_addr),
      .b_wdata(r_wdata), .b_rdata(r_rdata)
   );

   // flag of side s: raised by the other side writing s's mailbox,
   // dropped by side s looking at its own mailbox
   generate
      for (genvar s = 0; s < NSIDE; s++) begin : g_flag
         logic set_s, clr_s;
         assign set_s = ctl[NSIDE-1-s].wr_stb & far_hit[NSIDE-1-s];
         assign clr_s = ctl[s].look_stb & own_hit[s];
         mbox_dpram_flag #(.MBOX_EN(MBOX_EN)) u_flag (
            .clk(clk), .rst_n(rst_n),
            .set_i(set_s), .clr_i(clr_s), .irq_n(irq_n[s])
         );
      end
   endgenerate

   assign l_irq_n = irq_n[0];
   assign r_irq_n = irq_n[1];
endmodule

// File: rtl/mbox_dpram_sva.sv
module mbox_dpram_sva #(
   parameter int ADDR_W  = 10,
   parameter int DATA_W  = 8,
   parameter bit MBOX_EN = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              l_en,
   input logic              l_wr,
   input logic              l_oe,
   input logic [ADDR_W-1:0] l_addr,
   input logic [DATA_W-1:0] l_wdata,
   input logic [DATA_W-1:0] l_rdata,
   input logic              l_irq_n,
   input logic              r_en,
   input logic              r_wr,
   input logic              r_oe,
   input logic [ADDR_W-1:0] r_addr,
   input logic [DATA_W-1:0] r_wdata,
   input logic [DATA_W-1:0] r_rdata,
   input logic              r_irq_n
);
   localparam int DEPTH = 1 << ADDR_W;
   localparam logic [ADDR_W-1:0] BOX_L = ADDR_W'(DEPTH - 2);
   localparam logic [ADDR_W-1:0] BOX_R = ADDR_W'(DEPTH - 1);

   logic set_l, clr_l, set_r, clr_r;
   assign set_l = MBOX_EN && r_en && r_wr && (r_addr == BOX_L);
   assign clr_l = l_en && l_oe && (l_addr == BOX_L);
   assign set_r = MBOX_EN && l_en && l_wr && (l_addr == BOX_R);
   assign clr_r = r_en && r_oe && (r_addr == BOX_R);

   p_reset_r1: assert property (@(posedge clk)
      !rst_n |=> (l_irq_n && r_irq_n && l_rdata == '0 && r_rdata == '0));

   p_set_left_r4: assert property (@(posedge clk) disable iff (!rst_n)
      set_l |=> !l_irq_n);

   p_set_right_r6: assert property (@(posedge clk) disable iff (!rst_n)
      set_r |=> !r_irq_n);

   p_clear_left_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_l && !set_l) |=> l_irq_n);

   p_clear_right_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_r && !set_r) |=> r_irq_n);

   p_flag_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_l && !clr_l && !set_r && !clr_r) |=> ($stable(l_irq_n) && $stable(r_irq_n)));

   p_rdata_hold_l_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !(l_en && !l_wr && l_oe) |=> $stable(l_rdata));

   p_rdata_hold_r_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !(r_en && !r_wr && r_oe) |=> $stable(r_rdata));

   p_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!l_en && !r_en) |=> ($stable(l_irq_n) && $stable(r_irq_n)));

   logic unused_w;
   assign unused_w = ^{l_wdata, r_wdata};
endmodule

bind mbox_dpram mbox_dpram_sva #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MBOX_EN(MBOX_EN)
) u_sva (.*);

// File: tb/mbox_dpram_tb.sv
module mbox_dpram_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       l_en = 0, l_wr = 0, l_oe = 0;
   logic [9:0] l_addr = '0;
   logic [7:0] l_wdata = '0;
   logic [7:0] l_rdata;
   logic       l_irq_n;
   logic       r_en = 0, r_wr = 0, r_oe = 0;
   logic [9:0] r_addr = '0;
   logic [7:0] r_wdata = '0;
   logic [7:0] r_rdata;
   logic       r_irq_n;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   mbox_dpram u_dut (
      .clk(clk), .rst_n(rst_n),
      .l_en(l_en), .l_wr(l_wr), .l_oe(l_oe), .l_addr(l_addr),
      .l_wdata(l_wdata), .l_rdata(l_rdata), .l_irq_n(l_irq_n),
      .r_en(r_en), .r_wr(r_wr), .r_oe(r_oe), .r_addr(r_addr),
      .r_wdata(r_wdata), .r_rdata(r_rdata), .r_irq_n(r_irq_n)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic drv_l(input logic en, input logic wr, input logic oe,
                        input logic [9:0] a, input logic [7:0] d);
      l_en = en; l_wr = wr; l_oe = oe; l_addr = a; l_wdata = d;
   endtask

   task automatic drv_r(input logic en, input logic wr, input logic oe,
                        input logic [9:0] a, input logic [7:0] d);
      r_en = en; r_wr = wr; r_oe = oe; r_addr = a; r_wdata = d;
   endtask

   task automatic idle();
      drv_l(0, 0, 0, '0, '0);
      drv_r(0, 0, 0, '0, '0);
   endtask

   // one clock edge, then sample at the falling edge
   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic t_reset();
      check("R1 l_rdata", l_rdata, 8'h00);
      check("R1 r_rdata", r_rdata, 8'h00);
      check("R1 l_irq_n", {7'b0, l_irq_n}, 8'h01);
      check("R1 r_irq_n", {7'b0, r_irq_n}, 8'h01);
   endtask

   task automatic t_basic();
      drv_l(1, 1, 0, 10'h005, 8'hA5); step();
      idle(); drv_r(1, 0, 1, 10'h005, 8'h00); step();
      check("R2 right reads left write", r_rdata, 8'hA5);
      idle(); drv_r(1, 1, 0, 10'h200, 8'h3C); step();
      idle(); drv_l(1, 0, 1, 10'h200, 8'h00); step();
      check("R2 left reads right write", l_rdata, 8'h3C);
      idle();
   endtask

   task automatic t_disabled();
      drv_l(0, 1, 1, 10'h005, 8'hFF); drv_r(0, 1, 1, 10'h3FE, 8'h99); step();
      check("R3 disabled right no flag", {7'b0, l_irq_n}, 8'h01);
      idle(); drv_r(1, 0, 1, 10'h005, 8'h00); step();
      check("R3 disabled left no write", r_rdata, 8'hA5);
      idle(); drv_r(0, 0, 1, 10'h200, 8'h00); step();
      check("R3 disabled read holds", r_rdata, 8'hA5);
      idle();
   endtask

   task automatic t_left_irq();
      drv_r(1, 1, 0, 10'h3FE, 8'h5A); step();
      check("R4 left irq set", {7'b0, l_irq_n}, 8'h00);
      check("R4 right irq untouched", {7'b0, r_irq_n}, 8'h01);
      idle(); drv_l(1, 0, 1, 10'h3FE, 8'h00); step();
      check("R7 left mailbox data", l_rdata, 8'h5A);
      check("R5 left irq cleared by read", {7'b0, l_irq_n}, 8'h01);
      idle(); drv_r(1, 1, 0, 10'h3FE, 8'h66); step();
      check("R4 left irq set again", {7'b0, l_irq_n}, 8'h00);
      idle(); drv_l(1, 1, 1, 10'h3FE, 8'h77); step();
      check("R5 clear with write high", {7'b0, l_irq_n}, 8'h01);
      idle();
   endtask

   task automatic t_right_irq();
      drv_l(1, 1, 0, 10'h3FF, 8'hC3); step();
      check("R6 right irq set", {7'b0, r_irq_n}, 8'h00);
      idle(); drv_l(1, 1, 0, 10'h3FE, 8'h12); step();
      check("R7 own mailbox write no flag", {7'b0, l_irq_n}, 8'h01);
      idle(); drv_l(1, 0, 1, 10'h3FE, 8'h00); step();
      check("R7 own mailbox stored", l_rdata, 8'h12);
      idle(); drv_r(1, 0, 0, 10'h3FF, 8'h00); step();
      check("R11 no oe keeps flag", {7'b0, r_irq_n}, 8'h00);
      check("R11 no oe keeps rdata", r_rdata, 8'hA5);
      idle(); drv_r(1, 0, 1, 10'h3FF, 8'h00); step();
      check("R7 right mailbox data", r_rdata, 8'hC3);
      check("R6 right irq cleared", {7'b0, r_irq_n}, 8'h01);
      idle();
   endtask

   task automatic t_set_wins();
      drv_r(1, 1, 0, 10'h3FE, 8'h11); drv_l(1, 0, 1, 10'h3FE, 8'h00); step();
      check("R8 set beats clear", {7'b0, l_irq_n}, 8'h00);
      check("R10 read sees old word", l_rdata, 8'h12);
      idle(); drv_l(1, 0, 1, 10'h3FE, 8'h00); step();
      check("R10 new word after", l_rdata, 8'h11);
      check("R5 cleared after", {7'b0, l_irq_n}, 8'h01);
      idle();
   endtask

   task automatic t_collide();
      drv_l(1, 1, 0, 10'h100, 8'hAA); drv_r(1, 1, 0, 10'h100, 8'h55); step();
      idle(); drv_r(1, 0, 1, 10'h100, 8'h00); step();
      check("R9 left wins collision", r_rdata, 8'hAA);
      idle();
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      step();
      t_reset();
      t_basic();
      t_disabled();
      t_left_irq();
      t_right_irq();
      t_set_wins();
      t_collide();
      step();
      finish_run();
   end

   initial begin
      #(4 * 100000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end
endmodule